// File: doc/BRIEF.md
# Programmable 64-bit Interval Timer

This peripheral counts up toward a programmable 64-bit limit and raises a period flag each time the count reaches that limit. Software reaches it over a simple register bus whose data width is half the counter width (32 bits by default). The count can be clocked from the bus clock or from a slower, asynchronous generic clock. In both cases a 4-bit prescale value P divides the selected clock by P+1.

The timer runs in one of two modes. In continuous mode the count wraps to zero on every match. In one-shot mode the timer stops after the first match and waits for software to start it again. A software-reset command stops the timer and clears its counting state but keeps its configuration. The full count is read with two bus reads that always give one coherent value. Reading the lower half captures the upper half at the same moment.

The generic clock is not used to clock the counter. Each of its rising edges toggles a flop in its own domain. The bus domain synchronises that toggle and turns each change into a one-cycle tick, and the counter advances on the bus clock.

Top module: `ivtimer64`

## Requirements
- R1: After system reset the count, the status flag, the prescaler phase and every programmable register are zero, the timer is stopped, and `irq` is low.
- R2: The mode register (offset 0x04) holds three fields:
  - bit 0: continuous mode when 1, one-shot mode when 0;
  - bit 3: 1 selects the generic clock;
  - bits 11:8: the prescale value P.

  The mode register reads back exactly these fields, and all other bits read as zero. The enable register (0x10) reads back bit 0.
- R3: Writing the control register (0x00) with bit 0 set starts the timer. While it runs, the count advances by one every P+1 ticks of the selected clock. With the bus clock selected, every bus cycle is one tick. The first advance comes P+1 ticks after the start.
- R4: When the count equals the period on an advance, the count becomes zero instead of incrementing and the status flag sets. A period of N therefore gives one event every N+1 advances.
- R5: In one-shot mode the timer stops after an event with the count at zero. It stays there until a new start command.
- R6: Writing the control register with bit 8 set clears the count, the status flag and the prescaler phase, and stops the timer. This takes precedence over bit 0 in the same write. The mode, period and enable registers keep their values.
- R7: A write to 0x0C only stages the upper half of the period. The full period {staged, written} takes effect when 0x08 is written. Reads of 0x08 and 0x0C return the active period.
- R8: The status register (0x1C, bit 0) clears when it is read. An event in the same cycle as that read leaves the flag set.
- R9: `irq` equals the status flag AND enable bit 0, registered state only.
- R10: A read of 0x20 returns the lower half of the count and captures the upper half. A read of 0x24 returns the captured upper half, however many cycles later it comes.
- R11: With the generic clock selected, every rising edge of `genClk` is one tick, and the count does not move while `genClk` is idle. This requires that `genClk` runs at no more than one third of the `clk` rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all counting state runs on it |
| rstN | input | 1 | Active-low asynchronous system reset |
| genClk | input | 1 | Slow generic clock, at most one third of clk |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte offset of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid in the access cycle |
| irq | output | 1 | Period interrupt request |

## Verification
The bench aims at the following corner cases, each with the failure it would expose:

- **Status read in the same cycle as an event.** Status reads are repeated at a stride that lands some of them on the very cycle of an event. A design that lets the clear win would drop interrupts.
- **Coherent count read.** A lower-half read is taken just before the count carries into the upper half, and the upper half is read after the carry. A design that does not capture the upper half would return a torn value.
- **Half-written period.** A staged upper period that has not yet been committed must not change the readback. The test fails if it does.
- **Reset with both control bits.** A reset written together with a start must leave the timer stopped. Exposes a start that wins over the reset.
- **Generic clock counting.** In generic-clock mode the bench checks that the count equals the number of edges divided by P+1. It also checks that the count stays put while `genClk` is idle. A design that counts bus cycles, or that double-counts an edge, is caught.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam logic [5:0] ADDR_CTRL   = 6'h00;
  localparam logic [5:0] ADDR_MODE   = 6'h04;
  localparam logic [5:0] ADDR_PER_LO = 6'h08;
  localparam logic [5:0] ADDR_PER_HI = 6'h0C;
  localparam logic [5:0] ADDR_IEN    = 6'h10;
  localparam logic [5:0] ADDR_STAT   = 6'h1C;
  localparam logic [5:0] ADDR_CNT_LO = 6'h20;
  localparam logic [5:0] ADDR_CNT_HI = 6'h24;

  localparam int BIT_START = 0;
  localparam int BIT_SWRST = 8;
  localparam int BIT_CONT  = 0;
  localparam int BIT_GSEL  = 3;
  localparam int PRES_LSB  = 8;

  typedef struct packed {
    logic start;
    logic swReset;
    logic loadPeriod;
    logic clearStatus;
    logic latchHigh;
    logic countPulse;
  } ivtStrobe_t;
endpackage

// File: rtl/ivt_tick_sync.sv
module ivt_tick_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic genClk,
  input  logic clk,
  input  logic rstN,
  output logic tickPulse
);
  logic genToggle;
  logic [SYNC_STAGES:0] syncReg;

  // One toggle per rising edge of the slow clock.
  always_ff @(posedge genClk or negedge rstN) begin
    if (!rstN) genToggle <= 1'b0;
    else       genToggle <= ~genToggle;
  end

  // Synchroniser stages plus one stage for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '0;
    else       syncReg <= {syncReg[SYNC_STAGES-1:0], genToggle};
  end

  assign tickPulse = syncReg[SYNC_STAGES] ^ syncReg[SYNC_STAGES-1];

  // R11: the slow clock is at most a third of clk, so ticks never come back to back.
  a_r11_single_tick: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |=> !tickPulse);
endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRES_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [5:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              genTick,
  input  logic              running,
  output ivtStrobe_t        strobe,
  output logic              contMode,
  output logic              genSel,
  output logic [PRES_W-1:0] presVal,
  output logic              irqEn,
  output logic [DATA_W-1:0] periodStage
);
  logic wrEn, rdEn, modeWr, tick, pscHit;
  logic [PRES_W-1:0] presCnt;

  assign wrEn   = busSel &  busWrite;
  assign rdEn   = busSel & ~busWrite;
  assign modeWr = wrEn && (busAddr == ADDR_MODE);

  // Configuration registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      contMode    <= 1'b0;
      genSel      <= 1'b0;
      presVal     <= '0;
      irqEn       <= 1'b0;
      periodStage <= '0;
    end else if (wrEn) begin
      case (busAddr)
        ADDR_MODE: begin
          contMode <= busWdata[BIT_CONT];
          genSel   <= busWdata[BIT_GSEL];
          presVal  <= busWdata[PRES_LSB +: PRES_W];
        end
        ADDR_IEN:    irqEn       <= busWdata[0];
        ADDR_PER_HI: periodStage <= busWdata;
        default: ;
      endcase
    end
  end

  // Tick source and prescaler.
  assign tick   = genSel ? genTick : 1'b1;
  assign pscHit = (presCnt == presVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              presCnt <= '0;
    else if (strobe.swReset || !running)    presCnt <= '0;
    else if (tick)                          presCnt <= pscHit ? '0 : presCnt + 1'b1;
  end

  // Strobes to the datapath.
  always_comb begin
    strobe.start       = wrEn && (busAddr == ADDR_CTRL) && busWdata[BIT_START];
    strobe.swReset     = wrEn && (busAddr == ADDR_CTRL) && busWdata[BIT_SWRST];
    strobe.loadPeriod  = wrEn && (busAddr == ADDR_PER_LO);
    strobe.clearStatus = rdEn && (busAddr == ADDR_STAT);
    strobe.latchHigh   = rdEn && (busAddr == ADDR_CNT_LO);
    strobe.countPulse  = running && tick && pscHit;
  end

  // R6: reset clears the prescaler phase.
  a_r6_psc_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swReset |=> (presCnt == '0));
  // R3: with P > 0 two advances never come in consecutive cycles.
  a_r3_prescale_gap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countPulse && presVal != '0 && !modeWr) |=> !strobe.countPulse);
endmodule

// File: rtl/ivt_datapath.sv
module ivt_datapath
  import ivt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ivtStrobe_t        strobe,
  input  logic              contMode,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] periodStage,
  output logic              running,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  period,
  output logic              status,
  output logic [DATA_W-1:0] hiLatch
);
  logic periodEvent;

  assign periodEvent = strobe.countPulse && (count == period);

  // Counter and run state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      running <= 1'b0;
    end else if (strobe.swReset) begin
      count   <= '0;
      running <= 1'b0;
    end else begin
      if (strobe.countPulse) begin
        if (periodEvent) begin
          count <= '0;
          if (!contMode) running <= 1'b0;
        end else begin
          count <= count + 1'b1;
        end
      end
      if (strobe.start) running <= 1'b1;
    end
  end

  // Status flag: a new event wins over a clearing read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               status <= 1'b0;
    else if (strobe.swReset) status <= 1'b0;
    else                     status <= periodEvent | (status & ~strobe.clearStatus);
  end

  // Period commit and capture of the upper count half.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      period  <= '0;
      hiLatch <= '0;
    end else begin
      if (strobe.loadPeriod) period  <= {periodStage, busWdata};
      if (strobe.latchHigh)  hiLatch <= count[CNT_W-1:DATA_W];
    end
  end

  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (periodEvent && !strobe.swReset) |=> (count == '0));
  a_r8_event_kept: assert property (@(posedge clk) disable iff (!rstN)
    (periodEvent && !strobe.swReset) |=> status);
  a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rstN)
    (periodEvent && !contMode && !strobe.start) |=> !running);
  a_r6_sw_reset: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swReset |=> (count == '0 && !running && !status));
  a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strobe.swReset) |=> $stable(count));
endmodule

// File: rtl/ivtimer64.sv
module ivtimer64
  import ivt_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned PRES_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              genClk,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [5:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  ivtStrobe_t strobe;
  logic genTick, running, contMode, genSel, irqEn, status;
  logic [PRES_W-1:0] presVal;
  logic [DATA_W-1:0] periodStage, hiLatch;
  logic [CNT_W-1:0]  count, period;

  ivt_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .genClk(genClk), .clk(clk), .rstN(rstN), .tickPulse(genTick)
  );

  ivt_ctrl #(.DATA_W(DATA_W), .PRES_W(PRES_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .genTick(genTick),
    .running(running), .strobe(strobe), .contMode(contMode),
    .genSel(genSel), .presVal(presVal), .irqEn(irqEn),
    .periodStage(periodStage)
  );

  ivt_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .contMode(contMode),
    .busWdata(busWdata), .periodStage(periodStage), .running(running),
    .count(count), .period(period), .status(status), .hiLatch(hiLatch)
  );

  assign irq = status & irqEn;

  always_comb begin
    busRdata = '0;
    if (busSel && !busWrite) begin
      case (busAddr)
        ADDR_MODE: begin
          busRdata[BIT_CONT]            = contMode;
          busRdata[BIT_GSEL]            = genSel;
          busRdata[PRES_LSB +: PRES_W]  = presVal;
        end
        ADDR_PER_LO: busRdata    = period[DATA_W-1:0];
        ADDR_PER_HI: busRdata    = period[CNT_W-1:DATA_W];
        ADDR_IEN:    busRdata[0] = irqEn;
        ADDR_STAT:   busRdata[0] = status;
        ADDR_CNT_LO: busRdata    = count[DATA_W-1:0];
        ADDR_CNT_HI: busRdata    = hiLatch;
        default: ;
      endcase
    end
  end
endmodule

// File: tb/ivtimer64_test.sv
module ivtimer64_test;
  localparam int DW = 16;
  localparam int CW = 2 * DW;

  logic clk = 1'b0, rstN = 1'b0, genClk = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [5:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic irq;

  always #4 clk = ~clk;  // 125 MHz

  ivtimer64 #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .genClk(genClk), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq)
  );

  int nCmp = 0, nBad = 0;
  bit finished = 1'b0;

  // Behavioural reference state.
  logic [CW-1:0] mCount, mPeriod;
  logic [DW-1:0] mStage, mHi;
  logic [3:0] mP, mPsc;
  logic mRun, mStat, mCont, mGen, mIer;
  logic pulse, ev, rdOp, wrOp;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mRead(input logic [5:0] a);
    logic [DW-1:0] v = '0;
    case (a)
      6'h04: begin v[0] = mCont; v[3] = mGen; v[11:8] = mP; end
      6'h08: v = mPeriod[DW-1:0];
      6'h0C: v = mPeriod[CW-1:DW];
      6'h10: v[0] = mIer;
      6'h1C: v[0] = mStat;
      6'h20: v = mCount[DW-1:0];
      6'h24: v = mHi;
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCount = '0; mPeriod = '0; mStage = '0; mHi = '0; mP = '0; mPsc = '0;
      mRun = 0; mStat = 0; mCont = 0; mGen = 0; mIer = 0;
    end else begin
      rdOp  = busSel && !busWrite;
      wrOp  = busSel && busWrite;
      pulse = !mGen && mRun && (mPsc == mP);
      ev    = pulse && (mCount == mPeriod);
      if (rdOp && busAddr == 6'h20) mHi = mCount[CW-1:DW];
      mStat = ev | (mStat & !(rdOp && busAddr == 6'h1C));
      if (!mRun) mPsc = '0;
      else if (!mGen) mPsc = (mPsc == mP) ? 4'd0 : mPsc + 4'd1;
      if (pulse) begin
        if (ev) begin mCount = '0; if (!mCont) mRun = 0; end
        else mCount = mCount + 1'b1;
      end
      if (wrOp) begin
        case (busAddr)
          6'h00: if (busWdata[8]) begin mCount = '0; mRun = 0; mStat = 0; mPsc = '0; end
                 else if (busWdata[0]) mRun = 1;
          6'h04: begin mCont = busWdata[0]; mGen = busWdata[3]; mP = busWdata[11:8]; end
          6'h08: mPeriod = {mStage, busWdata};
          6'h0C: mStage = busWdata;
          6'h10: mIer = busWdata[0];
          default: ;
        endcase
      end
    end
  end

  // R9: interrupt compared with the reference on every clock.
  always @(negedge clk) if (rstN && !finished) check("R9 irq", irq, mStat & mIer);

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWr(input logic [5:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic rawRd(input logic [5:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic rdCheck(input string tag, input logic [5:0] a);
    logic [DW-1:0] exp;
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 exp = mRead(a);
    check(tag, busRdata, exp);
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic genPulses(input int n);
    repeat (n) begin
      #2 genClk = 1'b1;
      #12 genClk = 1'b0;
      #10;
    end
  endtask

  initial begin
    #(8 * 190000);
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    idle(3);
    rstN = 1'b1;
    // R1: reset state
    check("R1 irq low", irq, 0);
    rawRd(6'h20, v); check("R1 count lo", v, 0);
    rawRd(6'h1C, v); check("R1 status", v, 0);
    rawRd(6'h04, v); check("R1 mode", v, 0);
    rawRd(6'h08, v); check("R1 period", v, 0);

    // R2: mode fields and masking
    busWr(6'h04, 16'h0F09); rawRd(6'h04, v); check("R2 mode readback", v, 16'h0F09);
    busWr(6'h04, 16'hFFFF); rawRd(6'h04, v); check("R2 mode masked", v, 16'h0F09);
    busWr(6'h10, 16'hFFFF); rawRd(6'h10, v); check("R2 enable readback", v, 1);

    // R7: staged upper half
    busWr(6'h0C, 16'h0001); rawRd(6'h0C, v); check("R7 staged not active", v, 0);
    busWr(6'h08, 16'h0005); rawRd(6'h0C, v); check("R7 hi committed", v, 1);
    rdCheck("R7 lo committed", 6'h08);

    // R3/R4: continuous, P=2, period 4
    busWr(6'h0C, 0); busWr(6'h08, 4); busWr(6'h04, 16'h0201);
    busWr(6'h00, 16'h0001);
    for (int i = 0; i < 10; i++) begin
      rdCheck("R3 count advance", 6'h20);
      idle(1 + i);
    end
    rdCheck("R4 status after wraps", 6'h1C);
    rdCheck("R8 status cleared", 6'h1C);

    // R8: clearing reads colliding with events (period 2, P=0)
    busWr(6'h04, 16'h0001); busWr(6'h08, 2);
    for (int i = 0; i < 12; i++) rdCheck("R8 read vs event", 6'h1C);

    // R6: reset together with start
    busWr(6'h00, 16'h0101);
    rawRd(6'h20, v); check("R6 count cleared", v, 0);
    rawRd(6'h1C, v); check("R6 status cleared", v, 0);
    idle(5);
    rawRd(6'h20, v); check("R6 stays stopped", v, 0);
    rawRd(6'h04, v); check("R6 mode kept", v, 16'h0001);
    rawRd(6'h08, v); check("R6 period kept", v, 2);

    // R5: one-shot, period 3
    busWr(6'h04, 16'h0000); busWr(6'h08, 3);
    busWr(6'h00, 16'h0001);
    idle(12);
    rawRd(6'h20, v); check("R5 one-shot count zero", v, 0);
    rdCheck("R5 stopped count", 6'h20);
    rdCheck("R5 status set", 6'h1C);
    busWr(6'h00, 16'h0001); idle(1);
    rdCheck("R5 restart", 6'h20);

    // R10: coherent read across the carry into the upper half
    busWr(6'h00, 16'h0100);
    busWr(6'h0C, 16'hFFFF); busWr(6'h08, 16'hFFFF); busWr(6'h04, 16'h0001);
    busWr(6'h00, 16'h0001);
    idle(65500);
    rdCheck("R10 lo before carry", 6'h20);
    idle(60);
    rawRd(6'h24, v); check("R10 hi captured", v, 0);
    rdCheck("R10 lo after carry", 6'h20);
    rdCheck("R10 hi after carry", 6'h24);

    // R11: generic clock, P=1
    busWr(6'h00, 16'h0100);
    busWr(6'h0C, 0); busWr(6'h08, 16'hFFFF); busWr(6'h04, 16'h0109);
    busWr(6'h00, 16'h0001);
    genPulses(10); idle(6);
    rawRd(6'h20, v); check("R11 edges/2", v, 5);
    idle(10);
    rawRd(6'h20, v); check("R11 idle hold", v, 5);
    genPulses(6); idle(6);
    rawRd(6'h20, v); check("R11 more edges", v, 8);
    busWr(6'h00, 16'h0100);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule